// File: doc/BRIEF.md
# BCD Digit Adder with Segment Outputs

This block adds two decimal digits, each carried as a 4-bit code, together with a carry-in. It reports the result in two forms at the same time. The first is the plain 5-bit binary total, formed by a chain of full adders. The second is the corrected two-digit decimal result: a tens bit and a ones digit. The whole path is combinational, so every output follows the inputs within the same cycle.

A flag marks operands that are not decimal digits. Four 7-segment outputs show the two operands and the two result digits. A host places the block between an operand source and a display or a next stage. Wider decimal adders, registered outputs and pin mapping belong to the surrounding design.

Top module: `bcd_digit_adder`

## Requirements
- R1: `{bin_carry, bin_sum}` equals x_digit + y_digit + carry_in as a 5-bit binary number, for all 512 input combinations.
- R2: `digit_err` is 1 exactly when x_digit > 9 or y_digit > 9, and is 0 otherwise.
- R3: When both operands are at most 9, bcd_tens*10 + bcd_ones equals x_digit + y_digit + carry_in, and bcd_ones never exceeds 9.
- R4: When the total T = x_digit + y_digit + carry_in is 9 or less, bcd_tens is 0 and bcd_ones equals T. For example, a zero total reads as 00.
- R5: When T lies in 10..19, bcd_tens is 1 and bcd_ones equals T - 10. This also holds for totals 16..19, where bin_carry is set, so 9+9+1 reads as 19.
- R6: When digit_err is set, the decimal outputs are still produced from the raw inputs. In that case bcd_tens = (T > 9) and bcd_ones = (T - 10) mod 16 if T > 9, else T.
- R7: Segment outputs are active-low, with bit 0 = segment a through bit 6 = segment g. Written active-high as gfedcba in hex, the value v shows as: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, 10=77, 11=7C, 12=39, 13=5E, 14=79, 15=71. The inverse of that code appears on each output: seg_x shows x_digit, seg_y shows y_digit, seg_tens shows bcd_tens and seg_ones shows bcd_ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_digit | input | 4 | First decimal operand |
| y_digit | input | 4 | Second decimal operand |
| carry_in | input | 1 | Carry into the units position |
| bin_sum | output | 4 | Low four bits of the binary total |
| bin_carry | output | 1 | Carry out of the ripple chain |
| bcd_tens | output | 1 | Tens digit of the decimal result |
| bcd_ones | output | 4 | Ones digit of the decimal result |
| digit_err | output | 1 | Set when either operand exceeds 9 |
| seg_x | output | 7 | Active-low segments showing x_digit |
| seg_y | output | 7 | Active-low segments showing y_digit |
| seg_tens | output | 7 | Active-low segments showing bcd_tens |
| seg_ones | output | 7 | Active-low segments showing bcd_ones |

## Verification
The assertions check four things whenever the inputs settle: the arithmetic identity of the ripple total, the error flag's threshold, the value and range of the decimal result for legal operands, and that the tens display shows only 0 or 1. The exact glyph on each display cannot be checked that way. Neither can the wrapped ones digit produced for illegal operands, or the 16..19 band seen as a distinct scenario. Only the bench's sweep of all 512 operand and carry combinations, compared against its own decimal model, shows those.

// File: rtl/bcd_digit_pkg.sv
package bcd_digit_pkg;

   localparam int SEG_W = 7;

   // active-high glyph, bit 0 = segment a .. bit 6 = segment g
   function automatic logic [SEG_W-1:0] glyph_of(input logic [3:0] v);
      logic [SEG_W-1:0] g;
      case (v)
         4'h0: g = 7'h3F;
         4'h1: g = 7'h06;
         4'h2: g = 7'h5B;
         4'h3: g = 7'h4F;
         4'h4: g = 7'h66;
         4'h5: g = 7'h6D;
         4'h6: g = 7'h7D;
         4'h7: g = 7'h07;
         4'h8: g = 7'h7F;
         4'h9: g = 7'h6F;
         4'hA: g = 7'h77;
         4'hB: g = 7'h7C;
         4'hC: g = 7'h39;
         4'hD: g = 7'h5E;
         4'hE: g = 7'h79;
         default: g = 7'h71;
      endcase
      return g;
   endfunction

endpackage

// File: rtl/bcdx_full_add.sv
module bcdx_full_add (
   input  logic a_bit,
   input  logic b_bit,
   input  logic c_in,
   output logic s_bit,
   output logic c_out
);
   logic half_x;
   assign half_x = a_bit ^ b_bit;
   assign s_bit  = half_x ^ c_in;
   assign c_out  = (a_bit & b_bit) | (half_x & c_in);
endmodule

// File: rtl/bcdx_ripple.sv
module bcdx_ripple #(
   parameter int WIDTH = 4
) (
   input  logic [WIDTH-1:0] a_val,
   input  logic [WIDTH-1:0] b_val,
   input  logic             c_in,
   output logic [WIDTH-1:0] sum_val,
   output logic             c_out
);
   logic [WIDTH:0] chain;

   if (WIDTH < 1) begin : g_bad_width
      $error("bcdx_ripple: WIDTH must be at least 1");
   end

   assign chain[0] = c_in;

   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      bcdx_full_add u_fa (
         .a_bit (a_val[i]),
         .b_bit (b_val[i]),
         .c_in  (chain[i]),
         .s_bit (sum_val[i]),
         .c_out (chain[i+1])
      );
   end

   assign c_out = chain[WIDTH];
endmodule

// File: rtl/bcdx_dec_fix.sv
module bcdx_dec_fix #(
   parameter int DIGIT_W = 4
) (
   input  logic [DIGIT_W-1:0] raw_sum,
   input  logic               raw_carry,
   output logic               tens_out,
   output logic [DIGIT_W-1:0] ones_out
);
   localparam logic [DIGIT_W-1:0] ADJUST = DIGIT_W'(16 - 10);

   logic over_nine;
   logic [DIGIT_W-1:0] adjusted;

   if (DIGIT_W != 4) begin : g_bad_digit
      $error("bcdx_dec_fix: DIGIT_W must be 4");
   end

   // above nine when carry is set (16..31) or the low nibble is 10..15
   assign over_nine = raw_carry | (raw_sum[3] & (raw_sum[2] | raw_sum[1]));
   // adding six modulo 16 equals subtracting ten from the 5-bit total
   assign adjusted  = raw_sum + ADJUST;
   assign tens_out  = over_nine;
   assign ones_out  = over_nine ? adjusted : raw_sum;
endmodule

// File: rtl/bcdx_seg7.sv
module bcdx_seg7
   import bcd_digit_pkg::*;
#(
   parameter bit ACTIVE_LOW = 1'b1
) (
   input  logic [3:0]       value,
   output logic [SEG_W-1:0] seg
);
   logic [SEG_W-1:0] lit;
   assign lit = glyph_of(value);

   if (ACTIVE_LOW) begin : g_low
      assign seg = ~lit;
   end else begin : g_high
      assign seg = lit;
   end
endmodule

// File: rtl/bcd_digit_adder.sv
module bcd_digit_adder
   import bcd_digit_pkg::*;
#(
   parameter int DIGIT_W        = 4,
   parameter int DIGIT_MAX      = 9,
   parameter bit SEG_ACTIVE_LOW = 1'b1
) (
   input  logic [3:0] x_digit,
   input  logic [3:0] y_digit,
   input  logic       carry_in,
   output logic [3:0] bin_sum,
   output logic       bin_carry,
   output logic       bcd_tens,
   output logic [3:0] bcd_ones,
   output logic       digit_err,
   output logic [6:0] seg_x,
   output logic [6:0] seg_y,
   output logic [6:0] seg_tens,
   output logic [6:0] seg_ones
);
   localparam int TOTAL_W = DIGIT_W + 1;
   localparam logic [DIGIT_W-1:0] MAX_D = DIGIT_W'(DIGIT_MAX);

   if (DIGIT_W != 4) begin : g_bad_w
      $error("bcd_digit_adder: DIGIT_W must be 4");
   end
   if (DIGIT_MAX != 9) begin : g_bad_max
      $error("bcd_digit_adder: DIGIT_MAX must be 9");
   end

   bcdx_ripple #(.WIDTH(DIGIT_W)) u_add (
      .a_val   (x_digit),
      .b_val   (y_digit),
      .c_in    (carry_in),
      .sum_val (bin_sum),
      .c_out   (bin_carry)
   );

   bcdx_dec_fix #(.DIGIT_W(DIGIT_W)) u_fix (
      .raw_sum   (bin_sum),
      .raw_carry (bin_carry),
      .tens_out  (bcd_tens),
      .ones_out  (bcd_ones)
   );

   assign digit_err = (x_digit > MAX_D) | (y_digit > MAX_D);

   logic [3:0] tens_nib;
   assign tens_nib = {3'b000, bcd_tens};

   bcdx_seg7 #(.ACTIVE_LOW(SEG_ACTIVE_LOW)) u_seg_x (.value(x_digit),  .seg(seg_x));
   bcdx_seg7 #(.ACTIVE_LOW(SEG_ACTIVE_LOW)) u_seg_y (.value(y_digit),  .seg(seg_y));
   bcdx_seg7 #(.ACTIVE_LOW(SEG_ACTIVE_LOW)) u_seg_t (.value(tens_nib), .seg(seg_tens));
   bcdx_seg7 #(.ACTIVE_LOW(SEG_ACTIVE_LOW)) u_seg_o (.value(bcd_ones), .seg(seg_ones));

   // checks on settled combinational values
   logic [TOTAL_W-1:0] ref_total;
   logic [TOTAL_W-1:0] dec_total;
   assign ref_total = TOTAL_W'(x_digit) + TOTAL_W'(y_digit) + TOTAL_W'(carry_in);
   assign dec_total = (bcd_tens ? TOTAL_W'(10) : TOTAL_W'(0)) + TOTAL_W'(bcd_ones);

   always_comb begin
      // R1
      binary_total_chk: assert ({bin_carry, bin_sum} == ref_total)
         else $error("binary total mismatch");
      // R2
      digit_err_chk: assert (digit_err == ((x_digit >= 4'd10) || (y_digit >= 4'd10)))
         else $error("error flag mismatch");
      // R3
      decimal_value_chk: assert (digit_err || (dec_total == ref_total && bcd_ones <= 4'd9))
         else $error("decimal result mismatch");
      // R7
      tens_glyph_chk: assert (seg_tens == (SEG_ACTIVE_LOW ? ~glyph_of(4'd0) : glyph_of(4'd0))
                              || seg_tens == (SEG_ACTIVE_LOW ? ~glyph_of(4'd1) : glyph_of(4'd1)))
         else $error("tens display shows neither 0 nor 1");
   end
endmodule

// File: tb/tb_bcd_digit_adder.sv
module tb_bcd_digit_adder;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG_CYCLES = 200000;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [3:0] x_digit, y_digit;
   logic       carry_in;
   logic [3:0] bin_sum, bcd_ones;
   logic       bin_carry, bcd_tens, digit_err;
   logic [6:0] seg_x, seg_y, seg_tens, seg_ones;

   bcd_digit_adder dut (
      .x_digit(x_digit), .y_digit(y_digit), .carry_in(carry_in),
      .bin_sum(bin_sum), .bin_carry(bin_carry),
      .bcd_tens(bcd_tens), .bcd_ones(bcd_ones), .digit_err(digit_err),
      .seg_x(seg_x), .seg_y(seg_y), .seg_tens(seg_tens), .seg_ones(seg_ones)
   );

   int vectors = 0;
   int misses  = 0;
   bit done    = 1'b0;

   // active-low gfedcba codes taken from the requirement table (R7)
   function automatic logic [6:0] exp_seg(input int v);
      int hi;
      case (v)
         0: hi = 'h3F;  1: hi = 'h06;  2: hi = 'h5B;  3: hi = 'h4F;
         4: hi = 'h66;  5: hi = 'h6D;  6: hi = 'h7D;  7: hi = 'h07;
         8: hi = 'h7F;  9: hi = 'h6F; 10: hi = 'h77; 11: hi = 'h7C;
        12: hi = 'h39; 13: hi = 'h5E; 14: hi = 'h79; default: hi = 'h71;
      endcase
      return ~7'(hi);
   endfunction

   task automatic check(input string req, input string what, input int act, input int exp);
      if (act != exp) begin
         misses++;
         $display("FAIL %s %s x=%0d y=%0d c=%0d actual=%0d expected=%0d",
                  req, what, x_digit, y_digit, carry_in, act, exp);
      end
   endtask

   task automatic apply(input int xv, input int yv, input int cv);
      int total, e_tens, e_ones;
      bit e_err;
      @(posedge clk);
      #1;
      x_digit  = 4'(xv);
      y_digit  = 4'(yv);
      carry_in = 1'(cv);
      @(negedge clk);
      vectors++;
      total  = xv + yv + cv;
      e_err  = (xv > 9) || (yv > 9);
      e_tens = (total > 9) ? 1 : 0;
      e_ones = (total > 9) ? ((total - 10) % 16) : total;
      // R1
      check("R1", "bin_total", {bin_carry, bin_sum}, total);
      // R2
      check("R2", "digit_err", digit_err, e_err);
      if (!e_err) begin
         // R3
         check("R3", "decimal_value", (bcd_tens ? 10 : 0) + bcd_ones, total);
         if (total <= 9) begin
            // R4
            check("R4", "tens_low", bcd_tens, 0);
            check("R4", "ones_low", bcd_ones, total);
         end else begin
            // R5 (includes 16..19 where bin_carry is set)
            check("R5", "tens_high", bcd_tens, 1);
            check("R5", "ones_high", bcd_ones, total - 10);
         end
      end else begin
         // R6
         check("R6", "tens_err", bcd_tens, e_tens);
         check("R6", "ones_err", bcd_ones, e_ones);
      end
      // R7
      check("R7", "seg_x", seg_x, exp_seg(xv));
      check("R7", "seg_y", seg_y, exp_seg(yv));
      check("R7", "seg_tens", seg_tens, exp_seg(e_tens));
      check("R7", "seg_ones", seg_ones, exp_seg(e_ones));
   endtask

   initial begin
      x_digit = '0; y_digit = '0; carry_in = 1'b0;
      // zero operands first: result must read 00 (R4)
      apply(0, 0, 0);
      // named corners: ten (R5), top total 19 (R5), first carry 16 (R5)
      apply(5, 5, 0);
      apply(9, 9, 1);
      apply(8, 8, 0);
      apply(15, 15, 1);
      // full sweep of all 512 combinations
      for (int c = 0; c < 2; c++)
         for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
               apply(x, y, c);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!done) begin
         misses++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end
endmodule